// File: doc/BRIEF.md
# Two-Stage Pipelined Register ALU Datapath

This block is a compact execution core for register-to-register arithmetic and logic instructions of the shape `op rd, rs, rt`. Control is split between two instruction registers. The front register steers operand read from the register file. The back register steers the ALU and the write of the result into the register file. On every clock edge a new instruction word enters the front register, the front instruction moves to the back register, the two operands it names are captured into a pair of operand buffers, and the back instruction's result is committed. After the pipeline fills, one instruction retires per clock.

Instruction words come from an external instruction memory that is read combinationally through an address/data port. The program counter starts at zero and steps by one each clock. A separate combinational debug port reads any register, so the architectural state can be observed without disturbing the pipeline. When the back instruction writes a register that the front instruction reads on the same edge, the fresh ALU result is forwarded into the operand buffer. This lets back-to-back dependent instructions run without stalls.

Top module: `pipe2_alu_datapath`

## Requirements
- R1: While reset is asserted (active low), `imem_addr` is 0 and register i reads back the value i on the debug port, for all 16 registers.
- R2: After reset is released, `imem_addr` increases by exactly one on every rising clock edge.
- R3: An instruction word is decoded as opcode in bits 15:12, destination in bits 11:8, first source in bits 7:4 and second source in bits 3:0. Opcode 1 writes rs+rt, 2 writes rs-rt, 3 writes rs AND rt and 4 writes rs OR rt, all modulo 2^16.
- R4: The word presented on `imem_data` while `imem_addr` equals k is written to its destination register on the second rising edge after the edge that fetched it. The result is visible on the debug port right after that edge.
- R5: On the first two rising edges after reset is released, no register changes, because the back instruction register starts as a no-operation.
- R6: When an instruction reads a register that the immediately preceding instruction writes, it uses the new value on either source port.
- R7: Opcode 0 and opcodes 5 to 15 write no register.
- R8: Register 0 is an ordinary register that can be written and read back.
- R9: Once the pipeline is full, consecutive instructions commit on consecutive clock edges, with no bubbles.
- R10: `dbg_data` follows `dbg_addr` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | PC_W (8) | Word address of the next instruction to fetch |
| imem_data | input | 16 | Instruction word at `imem_addr`, combinational |
| dbg_addr | input | 4 | Register index for the debug read |
| dbg_data | output | DATA_W (16) | Contents of the register selected by `dbg_addr` |

## Verification
The hardest case to reach from the ports is the same-edge hazard. In that case the back instruction writes a register at the very edge where the front instruction latches it as an operand, and the forwarding path must win over the stale register-file value. The directed program places dependent instructions directly after their producers on the first source, on the second source, on both sources at once, and on register 0. A reference model of plain sequential execution is then compared against all sixteen registers after every edge, so a stale operand shows up as a mismatch in the exact cycle it commits.

// File: rtl/pipe2_pkg.sv
`timescale 1ns/1ps
package pipe2_pkg;

    localparam int RIDX_W  = 4;
    localparam int REG_CNT = 1 << RIDX_W;
    localparam int OPC_W   = 4;
    localparam int INSTR_W = OPC_W + 3 * RIDX_W;

    localparam logic [OPC_W-1:0] OPC_NOP = 4'd0;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'd1;
    localparam logic [OPC_W-1:0] OPC_SUB = 4'd2;
    localparam logic [OPC_W-1:0] OPC_AND = 4'd3;
    localparam logic [OPC_W-1:0] OPC_OR  = 4'd4;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
    } instr_t;

    typedef enum logic [2:0] {
        FN_NONE,
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR
    } alu_fn_t;

    function automatic alu_fn_t decode_fn(logic [OPC_W-1:0] opc);
        alu_fn_t fn;
        case (opc)
            OPC_ADD: fn = FN_ADD;
            OPC_SUB: fn = FN_SUB;
            OPC_AND: fn = FN_AND;
            OPC_OR:  fn = FN_OR;
            default: fn = FN_NONE;
        endcase
        return fn;
    endfunction

endpackage

// File: rtl/pipe2_alu.sv
`timescale 1ns/1ps
module pipe2_alu #(
    parameter int DATA_W = 16
) (
    input  pipe2_pkg::alu_fn_t  fn,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    output logic [DATA_W-1:0]   res,
    output logic                wr_en
);
    import pipe2_pkg::*;

    always_comb begin
        res   = '0;
        wr_en = 1'b1;
        case (fn)
            FN_ADD:  res = opa + opb;
            FN_SUB:  res = opa - opb;
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            default: wr_en = 1'b0;
        endcase
    end

    always_comb begin
        AST_NONE_NO_WRITE: assert (!(fn == FN_NONE && wr_en)); // R7
    end

endmodule

// File: rtl/pipe2_fwd.sv
`timescale 1ns/1ps
module pipe2_fwd #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] rf_val,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd
);
    logic hit;

    always_comb begin
        hit  = wb_en && (wb_idx == src_idx);
        opnd = hit ? wb_val : rf_val;
    end

endmodule

// File: rtl/pipe2_regfile.sv
`timescale 1ns/1ps
module pipe2_regfile #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int NPORT  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0][IDX_W-1:0]  rd_idx,
    output logic [NPORT-1:0][DATA_W-1:0] rd_val,
    input  logic [IDX_W-1:0]             dbg_idx,
    output logic [DATA_W-1:0]            dbg_val,
    input  logic                         we,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_val
);
    localparam int NREG = 1 << IDX_W;

    logic [NREG-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem_q[i] <= DATA_W'(i);
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rd_val[p] = mem_q[rd_idx[p]];
    end

    assign dbg_val = mem_q[dbg_idx];

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q)); // R7

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(wr_idx)] == $past(wr_val)); // R8

endmodule

// File: rtl/pipe2_alu_datapath.sv
`timescale 1ns/1ps
module pipe2_alu_datapath #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [15:0]       imem_data,
    input  logic [3:0]        dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    import pipe2_pkg::*;

    localparam int NSRC = 2;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        instr_t            front;
        instr_t            back;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    logic [NSRC-1:0][RIDX_W-1:0] src_idx;
    logic [NSRC-1:0][DATA_W-1:0] rf_val;
    logic [NSRC-1:0][DATA_W-1:0] fwd_val;
    alu_fn_t                     alu_fn;
    logic [DATA_W-1:0]           alu_res;
    logic                        wr_en;

    assign src_idx[0] = st_q.front.rs;
    assign src_idx[1] = st_q.front.rt;
    assign alu_fn     = decode_fn(st_q.back.opc);

    pipe2_alu #(.DATA_W(DATA_W)) i_alu (
        .fn    (alu_fn),
        .opa   (st_q.opa),
        .opb   (st_q.opb),
        .res   (alu_res),
        .wr_en (wr_en)
    );

    pipe2_regfile #(.DATA_W(DATA_W), .IDX_W(RIDX_W), .NPORT(NSRC)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (src_idx),
        .rd_val  (rf_val),
        .dbg_idx (dbg_addr),
        .dbg_val (dbg_data),
        .we      (wr_en),
        .wr_idx  (st_q.back.rd),
        .wr_val  (alu_res)
    );

    for (genvar p = 0; p < NSRC; p++) begin : g_fwd
        pipe2_fwd #(.DATA_W(DATA_W), .IDX_W(RIDX_W)) i_fwd (
            .src_idx (src_idx[p]),
            .rf_val  (rf_val[p]),
            .wb_en   (wr_en),
            .wb_idx  (st_q.back.rd),
            .wb_val  (alu_res),
            .opnd    (fwd_val[p])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.pc    = st_q.pc + PC_W'(1);
        st_d.front = instr_t'(imem_data);
        st_d.back  = st_q.front;
        st_d.opa   = fwd_val[0];
        st_d.opb   = fwd_val[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr = st_q.pc;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> imem_addr == $past(imem_addr) + PC_W'(1)); // R2

    AST_BACK_FROM_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.back == $past(st_q.front)); // R4

    AST_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.back.rd == st_q.front.rs) |=> st_q.opa == $past(alu_res)); // R6

    AST_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.back.rd == st_q.front.rt) |=> st_q.opb == $past(alu_res)); // R6

    AST_START_EMPTY: assert property (@(posedge clk)
        $rose(rst_n) |-> (st_q.back.opc == OPC_NOP && !wr_en)); // R5

endmodule

// File: tb/test_pipe2_alu_datapath.sv
`timescale 1ns/100ps
module test_pipe2_alu_datapath;

    localparam int DATA_W = 16;
    localparam int PC_W   = 8;
    localparam int DEPTH  = 1 << PC_W;
    localparam int NCYC   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   imem_addr;
    logic [15:0]       imem_data;
    logic [3:0]        dbg_addr = '0;
    logic [DATA_W-1:0] dbg_data;

    logic [15:0]       prog [DEPTH];
    logic [DATA_W-1:0] ref_regs [16];
    int                n_chk  = 0;
    int                n_fail = 0;
    bit                done   = 1'b0;

    always #4 clk = ~clk;

    assign imem_data = prog[imem_addr];

    pipe2_alu_datapath #(.DATA_W(DATA_W), .PC_W(PC_W)) i_pipe2_alu_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data)
    );

    function automatic logic [15:0] mk(int op, int rd, int rs, int rt);
        return {4'(op), 4'(rd), 4'(rs), 4'(rt)};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_exec(logic [15:0] w);
        logic [DATA_W-1:0] a, b;
        a = ref_regs[w[7:4]];
        b = ref_regs[w[3:0]];
        case (w[15:12])
            4'd1: ref_regs[w[11:8]] = a + b;
            4'd2: ref_regs[w[11:8]] = a - b;
            4'd3: ref_regs[w[11:8]] = a & b;
            4'd4: ref_regs[w[11:8]] = a | b;
            default: ;
        endcase
    endfunction

    task automatic read_reg(int r, output logic [DATA_W-1:0] v);
        dbg_addr = 4'(r);
        #0.1;
        v = dbg_data;
    endtask

    task automatic test_reset();
        logic [DATA_W-1:0] v;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "imem_addr in reset", 32'(imem_addr), 32'd0);
        for (int r = 0; r < 16; r++) begin
            read_reg(r, v);
            chk("R1", $sformatf("reg %0d in reset", r), 32'(v), 32'(r));
        end
    endtask

    task automatic test_debug_comb();
        logic [DATA_W-1:0] v;
        for (int r = 15; r >= 0; r--) begin
            read_reg(r, v);
            chk("R10", $sformatf("same-cycle debug read reg %0d", r), 32'(v), 32'(r));
        end
    endtask

    task automatic test_program();
        logic [DATA_W-1:0] v;
        for (int r = 0; r < 16; r++) ref_regs[r] = DATA_W'(r);
        rst_n = 1'b1;
        for (int n = 1; n <= NCYC; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n >= 3) ref_exec(prog[n-3]);
            chk("R2", $sformatf("imem_addr after edge %0d", n), 32'(imem_addr), 32'(n));
            for (int r = 0; r < 16; r++) begin
                read_reg(r, v);
                chk(n <= 2 ? "R5" : "R4_R9", $sformatf("edge %0d reg %0d", n, r),
                    32'(v), 32'(ref_regs[r]));
            end
        end
    endtask

    task automatic test_final_values();
        logic [DATA_W-1:0] v;
        read_reg(1, v);  chk("R3", "ADD r1", 32'(v), 32'h5);
        read_reg(4, v);  chk("R6", "forwarded both sources r4", 32'(v), 32'hA);
        read_reg(5, v);  chk("R6", "forwarded first source r5", 32'(v), 32'h5);
        read_reg(6, v);  chk("R3", "AND r6", 32'(v), 32'h2);
        read_reg(0, v);  chk("R8", "OR into r0", 32'(v), 32'hA);
        read_reg(2, v);  chk("R7", "NOP target r2 untouched", 32'(v), 32'h2);
        read_reg(3, v);  chk("R7", "unknown opcode target r3 untouched", 32'(v), 32'h3);
        read_reg(9, v);  chk("R6", "SUB wrap then dependent ADD r9", 32'(v), 32'hFFFE);
        read_reg(12, v); chk("R8", "r0 as source r12", 32'(v), 32'h14);
        read_reg(13, v); chk("R6", "forwarded second source r13", 32'(v), 32'h1E);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) prog[i] = 16'h0000;
        prog[0]  = mk(1, 1, 2, 3);    // r1 = 5
        prog[1]  = mk(1, 4, 1, 1);    // r4 = 10, both sources forwarded
        prog[2]  = mk(2, 5, 4, 1);    // r5 = 5, first source forwarded
        prog[3]  = mk(3, 6, 4, 7);    // r6 = 2
        prog[4]  = mk(4, 0, 6, 8);    // r0 = 10
        prog[5]  = mk(0, 2, 1, 1);    // NOP with a destination field
        prog[6]  = mk(9, 3, 1, 1);    // unknown opcode
        prog[7]  = mk(2, 9, 10, 11);  // r9 = FFFF
        prog[8]  = mk(1, 9, 9, 9);    // r9 = FFFE
        prog[9]  = mk(1, 12, 0, 0);   // r12 = 20
        prog[10] = mk(1, 13, 0, 12);  // r13 = 30, second source forwarded
        test_reset();
        test_debug_comb();
        test_program();
        test_final_values();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule